// File: doc/BRIEF.md
# Indirect register access port

This block is the host-facing front end of a peripheral whose internal registers do not sit in the host address map. The host sees seven 16-bit locations: a status register, an indirect address register, four data registers and a read-only revision register. Each access to the internal space is a transaction. It is started by writing the indirect address register, and bit 7 of the written value chooses read (1) or write (0). The transaction then runs for a fixed number of internal cycles, during which a busy flag is raised. The host polls that flag before it touches the data registers again.

Internal registers are 32 bits wide. A write transaction stores data register 1 (upper half) and data register 0 (lower half) as one word. A read transaction returns one 16-bit half in data register 0, so a full word takes two reads. Address bit 0 selects the half and bits 6:1 select the word. The status register also holds two active-low reset controls, one for the whole peripheral and one for the converter side, and both are driven out on pins. A small internal register file stands in for the downstream functions so the access path can be exercised on its own.

Top module: `ireg_port`

## Requirements
- R1: The host offsets are status 0, address 1, data registers 0 to 3 at offsets 2 to 5, and revision 6. Offset 7 reads as zero.
- R2: Status bit 0 is busy (read-only), bit 1 is the sticky error flag, bit 2 is the global reset release and bit 3 is the codec reset release. All other bits read 0. After reset all status bits are 0. `global_rst_n_o` follows bit 2 and `codec_rst_n_o` follows bit 3, and the two bits are written independently.
- R3: The block accepts a write to the address register when it is idle and the global release bit is 1. Busy is then high from the cycle after that write for exactly LATENCY cycles, and the address register reads back the accepted 8-bit value.
- R4: When a write transaction (bit 7 = 0) completes, internal word bits 6:1 of the address receives {data1, data0}. Data registers 2 and 3 have no effect on the stored word.
- R5: When a read transaction (bit 7 = 1) completes, data register 0 receives bits 15:0 of word bits 6:1 if address bit 0 is 0, and bits 31:16 if it is 1. Data registers 1 to 3 are left unchanged.
- R6: A host write to the address register or to any data register while busy is 1 has no effect and sets the error flag. Writing status with bit 1 = 1 clears the flag. Status writes take effect even while busy.
- R7: While the global release bit is 0, every internal word is held at zero and address-register writes are dropped: no busy and no error.
- R8: Revision reads {BOARD_REV in 15:12, AUDIO_ABSENT in 11, zero in 10:8, MAJOR_REV in 7:4, MINOR_REV in 3:0}. Host writes to it have no effect.
- R9: Word indices at or above REG_COUNT read as zero, and writes to them are dropped without touching other words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for the register at `host_addr` (combinational) |
| global_rst_n_o | output | 1 | Active-low reset for the whole peripheral |
| codec_rst_n_o | output | 1 | Active-low reset for the converter side |

## Verification
The hardest case to reach is a host write that arrives while a transaction is still in flight. Software that polls correctly never does this. The bench therefore issues a data write and then a second address write on the cycles right after a launch, and confirms that neither changes state, that the error flag becomes sticky, and that the pending read still completes into data register 0. Clearing the internal store needs a drop of the global release bit between a write and a later read-back. The bench drives that through the status register.

// File: rtl/ireg_pkg.sv
// Shared constants and types for the indirect register access port.
// Assumes a 3-bit host offset and an 8-bit indirect address (bit 7 = read).
package ireg_pkg;

    localparam int HOST_AW   = 3;
    localparam int HOST_DW   = 16;
    localparam int DATA_REGS = 4;
    localparam int WORD_W    = 32;
    localparam int LOC_W     = 7;

    localparam logic [HOST_AW-1:0] OFS_STATUS = 3'd0;
    localparam logic [HOST_AW-1:0] OFS_ADDR   = 3'd1;
    localparam logic [HOST_AW-1:0] OFS_DATA0  = 3'd2;
    localparam logic [HOST_AW-1:0] OFS_REV    = 3'd6;

    localparam int ST_BUSY  = 0;
    localparam int ST_ERR   = 1;
    localparam int ST_GLOB  = 2;
    localparam int ST_CODEC = 3;

    // One indirect transaction: direction flag and internal location.
    typedef struct packed {
        logic             rd;
        logic [LOC_W-1:0] loc;
    } xact_t;

endpackage

// File: rtl/ireg_store.sv
// Internal register file of REG_COUNT 32-bit words, reached only through
// the sequencer. Held at zero while 'hold' is high. Indices at or above
// REG_COUNT read zero and ignore writes. Assumes REG_COUNT <= 64.
module ireg_store #(
    parameter int REG_COUNT = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          hold,
    input  logic                          wr_en,
    input  logic [ireg_pkg::LOC_W-2:0]    idx,
    input  logic [ireg_pkg::WORD_W-1:0]   wr_data,
    output logic [ireg_pkg::WORD_W-1:0]   rd_data
);
    import ireg_pkg::*;

    localparam int SEL_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;
    localparam logic [LOC_W-1:0] LIMIT = LOC_W'(REG_COUNT);

    logic [WORD_W-1:0] mem [REG_COUNT];
    logic              in_range;
    logic [SEL_W-1:0]  sel;

    assign in_range = ({1'b0, idx} < LIMIT);
    assign sel      = idx[SEL_W-1:0];

    // One storage word per entry: cleared by reset or hold, else written on a match.
    for (genvar g = 0; g < REG_COUNT; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n || hold) begin
                mem[g] <= '0;
            end else if (wr_en && in_range && (sel == SEL_W'(g))) begin
                mem[g] <= wr_data;
            end
        end
    end

    // Read path: selected word, or zero when out of range.
    always_comb begin
        rd_data = in_range ? mem[sel] : '0;
    end

    // A cycle after hold, every word (and so any read) is zero.
    assert_hold_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold) |-> (rd_data == '0));

endmodule

// File: rtl/ireg_seq.sv
// Transaction sequencer. A launch latches the transaction and raises busy
// on the next cycle for exactly LATENCY cycles. 'done' marks the last busy
// cycle, when the store or data register 0 is updated.
// Assumes launch is never raised while busy (the host decode gates it).
module ireg_seq #(
    parameter int LATENCY = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            launch,
    input  ireg_pkg::xact_t launch_op,
    output logic            busy,
    output logic            done,
    output ireg_pkg::xact_t op
);
    import ireg_pkg::*;

    localparam int CNT_W = $clog2(LATENCY + 1);
    localparam int RUN_W = $clog2(LATENCY + 2);

    logic [CNT_W-1:0] cnt_q;

    // Countdown of remaining busy cycles and capture of the launched transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            op    <= '0;
        end else if (launch) begin
            busy  <= 1'b1;
            cnt_q <= CNT_W'(LATENCY - 1);
            op    <= launch_op;
        end else if (busy) begin
            if (cnt_q == '0) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign done = busy && (cnt_q == '0);

    // Checker counter: length of the current busy run.
    logic [RUN_W-1:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= busy ? run_q + 1'b1 : '0;
    end

    assert_launch_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy);
    assert_busy_needs_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(launch));
    assert_busy_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == RUN_W'(LATENCY)));
    assert_no_launch_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !launch);

endmodule

// File: rtl/ireg_host_if.sv
// Host register decode: status and reset controls, address register, four
// data registers and the revision constant. Decides when a transaction may
// start, blocks writes during busy, and takes read results into data reg 0.
// Assumes one host write per strobe cycle; reads are side-effect free.
module ireg_host_if #(
    parameter logic [3:0] BOARD_REV    = 4'd3,
    parameter logic [3:0] MAJOR_REV    = 4'd2,
    parameter logic [3:0] MINOR_REV    = 4'd1,
    parameter logic       AUDIO_ABSENT = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         host_wr,
    input  logic [ireg_pkg::HOST_AW-1:0] host_addr,
    input  logic [ireg_pkg::HOST_DW-1:0] host_wdata,
    output logic [ireg_pkg::HOST_DW-1:0] host_rdata,
    input  logic                         busy,
    input  logic                         done,
    input  ireg_pkg::xact_t              op,
    input  logic [ireg_pkg::WORD_W-1:0]  rd_data,
    output logic                         launch,
    output ireg_pkg::xact_t              launch_op,
    output logic                         wr_en,
    output logic [ireg_pkg::WORD_W-1:0]  wr_data,
    output logic                         hold,
    output logic                         global_rst_n_o,
    output logic                         codec_rst_n_o
);
    import ireg_pkg::*;

    localparam logic [HOST_DW-1:0] REV_WORD =
        {BOARD_REV, AUDIO_ABSENT, 3'b000, MAJOR_REV, MINOR_REV};

    logic               glob_q, codec_q, err_q;
    logic [7:0]         addr_q;
    logic [HOST_DW-1:0] data_q [DATA_REGS];
    logic               wr_status, wr_addr, wr_data_any, blocked;
    logic [HOST_DW-1:0] half;

    assign wr_status   = host_wr && (host_addr == OFS_STATUS);
    assign wr_addr     = host_wr && (host_addr == OFS_ADDR);
    assign wr_data_any = host_wr && (host_addr >= OFS_DATA0) && (host_addr < OFS_REV);
    assign blocked     = busy && (wr_addr || wr_data_any);

    assign launch    = wr_addr && !busy && glob_q;
    assign launch_op = xact_t'(host_wdata[7:0]);
    assign wr_en     = done && !op.rd;
    assign wr_data   = {data_q[1], data_q[0]};
    assign hold      = !glob_q;
    assign half      = op.loc[0] ? rd_data[31:16] : rd_data[15:0];

    // Reset controls and sticky error: status writes apply at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_q  <= 1'b0;
            codec_q <= 1'b0;
            err_q   <= 1'b0;
        end else if (wr_status) begin
            glob_q  <= host_wdata[ST_GLOB];
            codec_q <= host_wdata[ST_CODEC];
            if (host_wdata[ST_ERR]) err_q <= 1'b0;
        end else if (blocked) begin
            err_q <= 1'b1;
        end
    end

    // Address register keeps the last accepted transaction.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (launch) addr_q <= host_wdata[7:0];
    end

    // Data registers: host writes while idle; register 0 also takes read results.
    for (genvar g = 0; g < DATA_REGS; g++) begin : g_data
        logic load_rd, load_host;
        assign load_rd   = (g == 0) && done && op.rd;
        assign load_host = host_wr && !busy && (host_addr == OFS_DATA0 + HOST_AW'(g));
        always_ff @(posedge clk) begin
            if (!rst_n)         data_q[g] <= '0;
            else if (load_rd)   data_q[g] <= half;
            else if (load_host) data_q[g] <= host_wdata;
        end
    end

    // Host read mux over the seven visible registers.
    always_comb begin
        host_rdata = '0;
        case (host_addr)
            OFS_STATUS: host_rdata = {12'b0, codec_q, glob_q, err_q, busy};
            OFS_ADDR:   host_rdata = {8'b0, addr_q};
            3'd2:       host_rdata = data_q[0];
            3'd3:       host_rdata = data_q[1];
            3'd4:       host_rdata = data_q[2];
            3'd5:       host_rdata = data_q[3];
            OFS_REV:    host_rdata = REV_WORD;
            default:    host_rdata = '0;
        endcase
    end

    assign global_rst_n_o = glob_q;
    assign codec_rst_n_o  = codec_q;

    assert_busy_blocks_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr && host_addr == 3'd3) |=> $stable(data_q[1]));
    assert_err_clear_only_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_q) |-> $past(wr_status && host_wdata[ST_ERR]));
    assert_held_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!global_rst_n_o && !busy && wr_addr) |=> !busy);
    assert_ready_reads_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op.rd) |=> (data_q[0] == $past(half)));

endmodule

// File: rtl/ireg_port.sv
// Top of the indirect register access port: host decode, transaction
// sequencer and internal register store. Host reads are combinational;
// every internal access goes through a LATENCY-cycle transaction.
module ireg_port #(
    parameter int         LATENCY      = 4,
    parameter int         REG_COUNT    = 8,
    parameter logic [3:0] BOARD_REV    = 4'd3,
    parameter logic [3:0] MAJOR_REV    = 4'd2,
    parameter logic [3:0] MINOR_REV    = 4'd1,
    parameter logic       AUDIO_ABSENT = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [2:0]  host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        global_rst_n_o,
    output logic        codec_rst_n_o
);
    import ireg_pkg::*;

    logic              busy, done, launch, wr_en, hold;
    xact_t             op, launch_op;
    logic [WORD_W-1:0] wr_data, rd_data;

    ireg_host_if #(
        .BOARD_REV(BOARD_REV), .MAJOR_REV(MAJOR_REV),
        .MINOR_REV(MINOR_REV), .AUDIO_ABSENT(AUDIO_ABSENT)
    ) u_host (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .busy(busy), .done(done), .op(op), .rd_data(rd_data),
        .launch(launch), .launch_op(launch_op),
        .wr_en(wr_en), .wr_data(wr_data), .hold(hold),
        .global_rst_n_o(global_rst_n_o), .codec_rst_n_o(codec_rst_n_o)
    );

    ireg_seq #(.LATENCY(LATENCY)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .launch_op(launch_op),
        .busy(busy), .done(done), .op(op)
    );

    ireg_store #(.REG_COUNT(REG_COUNT)) u_store (
        .clk(clk), .rst_n(rst_n), .hold(hold),
        .wr_en(wr_en), .idx(op.loc[LOC_W-1:1]),
        .wr_data(wr_data), .rd_data(rd_data)
    );

endmodule

// File: tb/ireg_port_bench.sv
`timescale 1ns/1ps
// Bench: behavioural model updated every clock and compared every cycle,
// plus directed checks for each requirement.
module ireg_port_bench;
    localparam int LAT  = 4;
    localparam int NREG = 8;
    localparam logic [15:0] REV_EXP = {4'd3, 1'b0, 3'b000, 4'd2, 4'd1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [15:0] host_wdata = 16'd0;
    logic [15:0] host_rdata;
    logic        global_rst_n_o, codec_rst_n_o;

    int errs = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ireg_port u_ireg_port (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .global_rst_n_o(global_rst_n_o), .codec_rst_n_o(codec_rst_n_o)
    );

    // ---------------- reference model ----------------
    logic        m_glob, m_codec, m_err;
    logic [7:0]  m_addr;
    int          m_left;
    logic [15:0] m_data [4];
    logic [31:0] m_regs [NREG];

    function automatic logic [15:0] model_rd(input logic [2:0] a);
        case (a)
            3'd0: return {12'b0, m_codec, m_glob, m_err, (m_left > 0)};
            3'd1: return {8'b0, m_addr};
            3'd2, 3'd3, 3'd4, 3'd5: return m_data[int'(a) - 2];
            3'd6: return REV_EXP;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R5";
            3'd3, 3'd4, 3'd5: return "R4";
            3'd6: return "R8";
            default: return "R1";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_glob = 0; m_codec = 0; m_err = 0; m_addr = 0; m_left = 0;
            for (int i = 0; i < 4; i++) m_data[i] = 0;
            for (int r = 0; r < NREG; r++) m_regs[r] = 0;
        end else begin
            bit b0, g0;
            int idx;
            logic [31:0] v32;
            b0 = (m_left > 0);
            g0 = m_glob;
            if (b0 && m_left == 1) begin
                idx = int'(m_addr[6:1]);
                if (m_addr[7]) begin
                    v32 = (idx < NREG) ? m_regs[idx] : 32'h0;
                    m_data[0] = m_addr[0] ? v32[31:16] : v32[15:0];
                end else if (g0 && idx < NREG) begin
                    m_regs[idx] = {m_data[1], m_data[0]};
                end
            end
            if (!g0) for (int r = 0; r < NREG; r++) m_regs[r] = 0;
            if (b0) m_left--;
            if (host_wr) begin
                case (host_addr)
                    3'd0: begin
                        m_glob = host_wdata[2];
                        m_codec = host_wdata[3];
                        if (host_wdata[1]) m_err = 0;
                    end
                    3'd1: begin
                        if (b0) m_err = 1;
                        else if (g0) begin m_addr = host_wdata[7:0]; m_left = LAT; end
                    end
                    3'd2, 3'd3, 3'd4, 3'd5: begin
                        if (b0) m_err = 1;
                        else m_data[int'(host_addr) - 2] = host_wdata;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Per-cycle comparison, sampled just before the rising edge.
    always @(negedge clk) begin
        #2;
        if (rst_n && !finished) begin
            checks++;
            if (host_rdata !== model_rd(host_addr)) begin
                errs++;
                $display("FAIL %s cycle compare offset %0d: actual=%h expected=%h",
                         tag_of(host_addr), host_addr, host_rdata, model_rd(host_addr));
            end
            checks++;
            if (global_rst_n_o !== m_glob || codec_rst_n_o !== m_codec) begin
                errs++;
                $display("FAIL R2 reset pins: actual=%b%b expected=%b%b",
                         global_rst_n_o, codec_rst_n_o, m_glob, m_codec);
            end
        end
    end

    // ---------------- tasks ----------------
    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk);
        #1 host_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    task automatic wait_idle(output int n);
        logic [15:0] s;
        n = 0;
        for (int k = 0; k < 1000; k++) begin
            bus_read(3'd0, s);
            if (!s[0]) break;
            n++;
        end
    endtask

    task automatic write32(input logic [7:0] a, input logic [31:0] v);
        int n;
        bus_write(3'd2, v[15:0]);
        bus_write(3'd3, v[31:16]);
        bus_write(3'd4, 16'h0);
        bus_write(3'd5, 16'h0);
        bus_write(3'd1, {1'b0, a[6:0]});
        wait_idle(n);
    endtask

    task automatic read16(input logic [7:0] a, output logic [15:0] v);
        int n;
        bus_write(3'd1, {8'h0, 1'b1, a[6:0]});
        wait_idle(n);
        bus_read(3'd2, v);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        logic [15:0] v;
        int n;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        bus_read(3'd0, v);   chk("R2 status after reset", v, 16'h0000);
        chk("R2 pins after reset", {14'b0, global_rst_n_o, codec_rst_n_o}, 16'h0000);
        bus_read(3'd6, v);   chk("R8 revision word", v, REV_EXP);
        bus_write(3'd6, 16'hFFFF);
        bus_read(3'd6, v);   chk("R8 revision ignores writes", v, REV_EXP);
        bus_read(3'd7, v);   chk("R1 unmapped offset", v, 16'h0000);

        bus_write(3'd1, 16'h0084);
        bus_read(3'd0, v);   chk("R7 address write dropped while held", v, 16'h0000);

        bus_write(3'd0, 16'h000C);
        chk("R2 both released", {14'b0, global_rst_n_o, codec_rst_n_o}, 16'h0003);

        bus_write(3'd2, 16'h1234);
        bus_write(3'd3, 16'hBEEF);
        bus_write(3'd1, 16'h0004);
        wait_idle(n);
        chk("R3 busy length", 16'(n), 16'(LAT));
        bus_read(3'd1, v);   chk("R3 address readback", v, 16'h0004);
        read16(8'h04, v);    chk("R5 low half", v, 16'h1234);
        read16(8'h05, v);    chk("R5 high half", v, 16'hBEEF);
        bus_read(3'd3, v);   chk("R5 data1 untouched by read", v, 16'hBEEF);

        bus_write(3'd2, 16'h1111);
        bus_write(3'd3, 16'h2222);
        bus_write(3'd4, 16'hFFFF);
        bus_write(3'd5, 16'hAAAA);
        bus_write(3'd1, 16'h0006);
        wait_idle(n);
        read16(8'h07, v);    chk("R4 upper from data1 only", v, 16'h2222);
        read16(8'h06, v);    chk("R4 lower from data0 only", v, 16'h1111);

        write32(8'h0A, 32'h0000_5A5A);
        read16(8'h0A, v);
        write32(8'h0A, {16'h0, v | 16'h0100});
        read16(8'h0A, v);    chk("R4 rmw set keeps other bits", v, 16'h5B5A);
        write32(8'h0A, {16'h0, v & ~16'h0002});
        read16(8'h0A, v);    chk("R4 rmw clear keeps other bits", v, 16'h5B58);
        read16(8'h0B, v);    chk("R4 upper stays zero", v, 16'h0000);

        bus_write(3'd1, 16'h008A);
        bus_write(3'd3, 16'h7777);
        bus_write(3'd1, 16'h000C);
        wait_idle(n);
        bus_read(3'd3, v);   chk("R6 data write during busy ignored", v, 16'h0000);
        bus_read(3'd1, v);   chk("R6 address write during busy ignored", v, 16'h008A);
        bus_read(3'd2, v);   chk("R6 pending read still completes", v, 16'h5B58);
        bus_read(3'd0, v);   chk("R6 sticky error set", v, 16'h000E);
        bus_write(3'd0, 16'h000E);
        bus_read(3'd0, v);   chk("R6 error cleared", v, 16'h000C);

        write32(8'h12, 32'hCAFE_F00D);
        read16(8'h12, v);    chk("R9 out of range reads zero", v, 16'h0000);
        read16(8'h02, v);    chk("R9 other word untouched", v, 16'h0000);

        bus_write(3'd0, 16'h0004);
        chk("R2 codec independent", {14'b0, global_rst_n_o, codec_rst_n_o}, 16'h0002);

        bus_write(3'd0, 16'h0000);
        repeat (3) @(posedge clk);
        bus_write(3'd0, 16'h000C);
        read16(8'h04, v);    chk("R7 hold cleared store", v, 16'h0000);

        repeat (4) @(posedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errs++;
            checks++;
            $display("FAIL R3 watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule